// File: doc/BRIEF.md
# Prioritised Local-to-PCI Address Window Translator

This block sits on the local-bus side of a host bridge and decides, for every local address presented to it, whether the address falls inside one of three programmable apertures and, if it does, which PCI address and cycle type the access becomes. Two general memory apertures each have a base register and a map register. A third aperture is reserved for I/O and always spans 16 MB.

Apertures may overlap. Software relies on this to hide one aperture temporarily behind a larger one, for example to borrow it for configuration cycles. The apertures are searched from index 0 upwards and the first one that matches wins. The result is registered, so it appears one clock after the address is presented. Configuration registers are loaded through a single write port and take effect on the next clock edge.

Top module: `lbx_xlat_top`

## Requirements
- R1: After reset every aperture is disabled, and the outputs read hit=0, index=0, address=0, cycle type=000 and prefetch=0.
- R2: A memory aperture is enabled by base bit 0. It matches when the address lies in the naturally aligned block of 2^(20+k) bytes that contains the address held in base bits 31:20. k is base bits 7:4, and codes 11 to 15 all mean 2 GB. A disabled aperture never matches.
- R3: On a memory hit, the translated address takes map bits 15:4 for the address bits at or above the aperture size. The bits below the aperture size, down to bit 2, are copied from the local address.
- R4: Map bit 0 set copies local address bits 1:0 to the output. Map bit 0 clear forces output bits 1:0 to 0.
- R5: A memory hit reports the map bits 3:1 as the cycle type. Defined codes are 000 interrupt acknowledge, 001 I/O, 011 memory, 101 configuration and 110 memory multiple. The same hit reports base bit 3 as the prefetch flag.
- R6: The I/O aperture is enabled by its base bit 0. It matches when address bits 31:24 equal its base bits 15:8. On a hit, output bits 31:24 come from its map bits 15:8 and bits 23:0 pass through unchanged. The index is 2, the cycle type is 001 and prefetch is 0.
- R7: When several apertures match, the lowest index wins: memory 0, then memory 1, then I/O.
- R8: When no enabled aperture matches, the outputs are hit=0, index=0, address=0, cycle type=000 and prefetch=0.
- R9: The result for an address appears one clock after it is presented. A register write takes effect at the next clock edge. A lookup presented in the same cycle as a write uses the old register values.
- R10: Write select codes are: 0 base of memory 0, 1 map of memory 0, 2 base of memory 1, 3 map of memory 1, 4 I/O base, 5 I/O map. Map writes use data bits 15:0. Codes 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code |
| wr_data | input | 32 | Register write data |
| lk_addr | input | 32 | Local address to translate |
| out_hit | output | 1 | Some aperture matched |
| out_idx | output | 2 | Index of the winning aperture |
| out_addr | output | 32 | Translated PCI address |
| out_cyc | output | 3 | PCI cycle type code |
| out_pref | output | 1 | Winning aperture is prefetchable |

## Verification
The assertions assume the lookup address is a defined value on every clock after reset. They also assume that aperture configuration changes only through the write port. The stimulus always drives a known address and changes inputs only on the falling edge.

Aperture sizes that are not power-of-two aligned cannot arise, because size codes above 11 are clamped. The sweeps therefore cover all sixteen size codes, including the clamped ones. The bench also uses overlapping apertures whose priority is known, so every case has a single correct winner.

// File: rtl/lbx_pkg.sv
package lbx_pkg;
  localparam int ADDR_W      = 32;
  localparam int MEM_CMP_LSB = 20;
  localparam int IO_CMP_LSB  = 24;
  localparam int MEM_HI_W    = ADDR_W - MEM_CMP_LSB;
  localparam int IO_HI_W     = ADDR_W - IO_CMP_LSB;
  localparam int MAX_SZ_CODE = 11;

  localparam logic [2:0] CYC_IO = 3'b001;

  typedef struct packed {
    logic [MEM_HI_W-1:0] base;
    logic [3:0]          size;
    logic                pref;
    logic                en;
    logic [MEM_HI_W-1:0] map;
    logic [2:0]          cyc;
    logic                low_en;
  } mem_cfg_t;

  typedef struct packed {
    logic [IO_HI_W-1:0] base;
    logic               en;
    logic [IO_HI_W-1:0] map;
  } io_cfg_t;
endpackage

// File: rtl/lbx_rst_sync.sv
module lbx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/lbx_win_regs.sv
module lbx_win_regs
  import lbx_pkg::*;
#(
  parameter int NUM_MEM_WIN = 2,
  localparam int SEL_W = $clog2(2*NUM_MEM_WIN+2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  output mem_cfg_t          mem_cfg [NUM_MEM_WIN],
  output io_cfg_t           io_cfg
);
  for (genvar i = 0; i < NUM_MEM_WIN; i++) begin : g_mem
    logic     we_base, we_map;
    mem_cfg_t cfg_nx;

    always_comb begin
      we_base = wr_en && (wr_sel == SEL_W'(2*i));
      we_map  = wr_en && (wr_sel == SEL_W'(2*i+1));
      cfg_nx  = mem_cfg[i];
      if (we_base) begin
        cfg_nx.base = wr_data[ADDR_W-1:MEM_CMP_LSB];
        cfg_nx.size = wr_data[7:4];
        cfg_nx.pref = wr_data[3];
        cfg_nx.en   = wr_data[0];
      end
      if (we_map) begin
        cfg_nx.map    = wr_data[15:4];
        cfg_nx.cyc    = wr_data[3:1];
        cfg_nx.low_en = wr_data[0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 mem_cfg[i] <= '0;
      else if (we_base || we_map) mem_cfg[i] <= cfg_nx;
    end
  end

  logic    io_we_base, io_we_map;
  io_cfg_t io_nx;

  always_comb begin
    io_we_base = wr_en && (wr_sel == SEL_W'(2*NUM_MEM_WIN));
    io_we_map  = wr_en && (wr_sel == SEL_W'(2*NUM_MEM_WIN+1));
    io_nx      = io_cfg;
    if (io_we_base) begin
      io_nx.base = wr_data[15:8];
      io_nx.en   = wr_data[0];
    end
    if (io_we_map) io_nx.map = wr_data[15:8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        io_cfg <= '0;
    else if (io_we_base || io_we_map)  io_cfg <= io_nx;
  end
endmodule

// File: rtl/lbx_mem_win.sv
module lbx_mem_win
  import lbx_pkg::*;
(
  input  mem_cfg_t          cfg,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] xaddr
);
  logic [3:0]          code;
  logic [MEM_HI_W-1:0] keep;
  logic [MEM_HI_W-1:0] hi_out;

  always_comb begin
    code   = (cfg.size > 4'(MAX_SZ_CODE)) ? 4'(MAX_SZ_CODE) : cfg.size;
    keep   = {MEM_HI_W{1'b1}} << code;
    hit    = cfg.en && (((addr[ADDR_W-1:MEM_CMP_LSB] ^ cfg.base) & keep) == '0);
    hi_out = (cfg.map & keep) | (addr[ADDR_W-1:MEM_CMP_LSB] & ~keep);
    xaddr  = {hi_out, addr[MEM_CMP_LSB-1:2], (cfg.low_en ? addr[1:0] : 2'b00)};
  end
endmodule

// File: rtl/lbx_io_win.sv
module lbx_io_win
  import lbx_pkg::*;
(
  input  io_cfg_t           cfg,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] xaddr
);
  always_comb begin
    hit   = cfg.en && (addr[ADDR_W-1:IO_CMP_LSB] == cfg.base);
    xaddr = {cfg.map, addr[IO_CMP_LSB-1:0]};
  end
endmodule

// File: rtl/lbx_xlat_top.sv
module lbx_xlat_top
  import lbx_pkg::*;
#(
  parameter int NUM_MEM_WIN = 2,
  localparam int SEL_W = $clog2(2*NUM_MEM_WIN+2),
  localparam int IDX_W = $clog2(NUM_MEM_WIN+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              out_hit,
  output logic [IDX_W-1:0]  out_idx,
  output logic [ADDR_W-1:0] out_addr,
  output logic [2:0]        out_cyc,
  output logic              out_pref
);
  logic rst_sync_n;

  lbx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mem_cfg_t mem_cfg [NUM_MEM_WIN];
  io_cfg_t  io_cfg;

  lbx_win_regs #(.NUM_MEM_WIN(NUM_MEM_WIN)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .mem_cfg (mem_cfg),
    .io_cfg  (io_cfg)
  );

  logic [NUM_MEM_WIN-1:0] mem_hit;
  logic [ADDR_W-1:0]      mem_xaddr [NUM_MEM_WIN];
  logic                   io_hit;
  logic [ADDR_W-1:0]      io_xaddr;

  for (genvar i = 0; i < NUM_MEM_WIN; i++) begin : g_match
    lbx_mem_win u_mem (
      .cfg   (mem_cfg[i]),
      .addr  (lk_addr),
      .hit   (mem_hit[i]),
      .xaddr (mem_xaddr[i])
    );
  end

  lbx_io_win u_io (
    .cfg   (io_cfg),
    .addr  (lk_addr),
    .hit   (io_hit),
    .xaddr (io_xaddr)
  );

  // Next-state: lowest index overrides, so scan from the top down.
  logic              hit_nx, pref_nx;
  logic [IDX_W-1:0]  idx_nx;
  logic [ADDR_W-1:0] addr_nx;
  logic [2:0]        cyc_nx;

  always_comb begin
    hit_nx  = io_hit;
    idx_nx  = IDX_W'(NUM_MEM_WIN);
    addr_nx = io_xaddr;
    cyc_nx  = CYC_IO;
    pref_nx = 1'b0;
    for (int i = NUM_MEM_WIN-1; i >= 0; i--) begin
      if (mem_hit[i]) begin
        hit_nx  = 1'b1;
        idx_nx  = IDX_W'(i);
        addr_nx = mem_xaddr[i];
        cyc_nx  = mem_cfg[i].cyc;
        pref_nx = mem_cfg[i].pref;
      end
    end
    if (!hit_nx) begin
      idx_nx  = '0;
      addr_nx = '0;
      cyc_nx  = '0;
      pref_nx = 1'b0;
    end
  end

  logic out_ce;
  assign out_ce = 1'b1;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_hit  <= 1'b0;
      out_idx  <= '0;
      out_addr <= '0;
      out_cyc  <= '0;
      out_pref <= 1'b0;
    end else if (out_ce) begin
      out_hit  <= hit_nx;
      out_idx  <= idx_nx;
      out_addr <= addr_nx;
      out_cyc  <= cyc_nx;
      out_pref <= pref_nx;
    end
  end
endmodule

// File: rtl/lbx_xlat_chk.sv
module lbx_xlat_chk
  import lbx_pkg::*;
#(
  parameter int NUM_MEM_WIN = 2,
  localparam int IDX_W = $clog2(NUM_MEM_WIN+1)
) (
  input logic                   clk,
  input logic                   rst_sync_n,
  input logic [ADDR_W-1:0]      lk_addr,
  input logic                   out_hit,
  input logic [IDX_W-1:0]       out_idx,
  input logic [ADDR_W-1:0]      out_addr,
  input logic [2:0]             out_cyc,
  input logic                   out_pref,
  input logic [NUM_MEM_WIN-1:0] mem_hit,
  input logic                   io_hit
);
  p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_hit |-> out_addr[MEM_CMP_LSB-1:2] == $past(lk_addr[MEM_CMP_LSB-1:2]));

  p_io_attr_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_hit && out_idx == IDX_W'(NUM_MEM_WIN)) |-> (out_cyc == CYC_IO && !out_pref));

  p_first_wins_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_hit && out_idx != '0) |-> !$past(mem_hit[0]));

  p_idx_range_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_hit |-> out_idx <= IDX_W'(NUM_MEM_WIN));

  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !out_hit |-> (out_addr == '0 && out_idx == '0 && out_cyc == '0 && !out_pref));

  p_hit_latency_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|mem_hit || io_hit) |=> out_hit);

  p_miss_latency_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(|mem_hit || io_hit) |=> !out_hit);
endmodule

bind lbx_xlat_top lbx_xlat_chk #(.NUM_MEM_WIN(NUM_MEM_WIN)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .lk_addr    (lk_addr),
  .out_hit    (out_hit),
  .out_idx    (out_idx),
  .out_addr   (out_addr),
  .out_cyc    (out_cyc),
  .out_pref   (out_pref),
  .mem_hit    (mem_hit),
  .io_hit     (io_hit)
);

// File: tb/test_lbx_xlat_top.sv
module test_lbx_xlat_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [31:0] wr_data;
  logic [31:0] lk_addr;
  logic        out_hit;
  logic [1:0]  out_idx;
  logic [31:0] out_addr;
  logic [2:0]  out_cyc;
  logic        out_pref;

  always #4 clk = ~clk;

  lbx_xlat_top i_lbx_xlat_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .lk_addr(lk_addr), .out_hit(out_hit), .out_idx(out_idx), .out_addr(out_addr),
    .out_cyc(out_cyc), .out_pref(out_pref)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Shadow of programmed register contents, kept by the bench.
  logic [31:0] sb_base [2];
  logic [15:0] sb_map  [2];
  logic [15:0] sb_iob, sb_iom;

  logic        e_hit, e_pref;
  logic [1:0]  e_idx;
  logic [31:0] e_addr;
  logic [2:0]  e_cyc;

  task automatic model(input logic [31:0] a);
    logic [63:0] size, start, mstart, av, t;
    int code;
    e_hit = 0; e_idx = 0; e_addr = 0; e_cyc = 0; e_pref = 0;
    av = {32'b0, a};
    for (int i = 0; i < 2; i++) begin
      if (!e_hit && sb_base[i][0]) begin
        code  = int'(sb_base[i][7:4]);
        if (code > 11) code = 11;
        size  = 64'd1 << (20 + code);
        start = ({32'b0, sb_base[i][31:20], 20'b0} / size) * size;
        if (av >= start && av < start + size) begin
          mstart = ({32'b0, sb_map[i][15:4], 20'b0} / size) * size;
          t      = mstart + (av - start);
          if (!sb_map[i][0]) t[1:0] = 2'b00;
          e_hit = 1; e_idx = 2'(i); e_addr = t[31:0];
          e_cyc = sb_map[i][3:1]; e_pref = sb_base[i][3];
        end
      end
    end
    if (!e_hit && sb_iob[0]) begin
      start = {40'b0, sb_iob[15:8]} * 64'h100_0000;
      if (av >= start && av < start + 64'h100_0000) begin
        t = {40'b0, sb_iom[15:8]} * 64'h100_0000 + (av - start);
        e_hit = 1; e_idx = 2'd2; e_addr = t[31:0]; e_cyc = 3'b001; e_pref = 0;
      end
    end
  endtask

  task automatic check(input string tag);
    n_checks++;
    if (out_hit !== e_hit || out_idx !== e_idx || out_addr !== e_addr ||
        out_cyc !== e_cyc || out_pref !== e_pref) begin
      n_fail++;
      $display("FAIL %s: got hit=%0b idx=%0d addr=%h cyc=%b pref=%0b, expected hit=%0b idx=%0d addr=%h cyc=%b pref=%0b",
               tag, out_hit, out_idx, out_addr, out_cyc, out_pref,
               e_hit, e_idx, e_addr, e_cyc, e_pref);
    end
  endtask

  task automatic shadow_wr(input logic [2:0] s, input logic [31:0] d);
    case (s)
      3'd0: sb_base[0] = d;
      3'd1: sb_map[0]  = d[15:0];
      3'd2: sb_base[1] = d;
      3'd3: sb_map[1]  = d[15:0];
      3'd4: sb_iob     = d[15:0];
      3'd5: sb_iom     = d[15:0];
      default: ;
    endcase
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_data = d;
    shadow_wr(s, d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(input logic [31:0] a, input string tag);
    @(negedge clk);
    lk_addr = a;
    model(a);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got running, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] start, size;
    for (int i = 0; i < 2; i++) begin sb_base[i] = 0; sb_map[i] = 0; end
    sb_iob = 0; sb_iom = 0;
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0; lk_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state, and nothing matches while all apertures are off
    model(32'h0); check("R1 reset outputs");
    look(32'h0000_0000, "R1 disabled");
    look(32'h4000_0000, "R1 disabled");
    look(32'hFFFF_FFFF, "R1 disabled");

    // R2/R3: sweep every size code with boundary addresses
    for (int code = 0; code < 16; code++) begin
      int c;
      c = (code > 11) ? 11 : code;
      size  = 32'h10_0000 << c;
      wr(3'd0, 32'h4560_0000 | (32'(code) << 4) | 32'h1);
      wr(3'd1, 32'h0000_ABC6);
      start = 32'h4560_0000 & ~(size - 1);
      look(start,                "R2 window start");
      look(start + size - 1,     "R2 window last byte");
      look(start + size,         "R2 above window");
      look(start - 1,            "R2 below window");
      look(start + (size >> 1) + 32'h1234, "R3 offset copy");
    end

    // R2: disabled aperture ignored
    wr(3'd0, 32'h4000_0080);
    look(32'h4000_0010, "R2 enable clear");

    // R4: low address bits
    wr(3'd0, 32'h4000_0041);
    wr(3'd1, 32'h0000_1237);
    look(32'h4001_2347, "R4 low bits pass");
    wr(3'd1, 32'h0000_1236);
    look(32'h4001_2347, "R4 low bits zero");

    // R5: every cycle-type code, prefetch on and off
    for (int k = 0; k < 8; k++) begin
      wr(3'd0, 32'h7000_0001 | ((k % 2) ? 32'h8 : 32'h0));
      wr(3'd1, 32'h0000_2200 | (32'(k) << 1));
      look(32'h700A_BCD0, "R5 cycle type and prefetch");
    end

    // R6: I/O aperture
    wr(3'd0, 32'h0); wr(3'd1, 32'h0);
    wr(3'd4, 32'h0000_6001);
    wr(3'd5, 32'h0000_A500);
    look(32'h6000_0000, "R6 io start");
    look(32'h60FF_FFFF, "R6 io last");
    look(32'h6100_0000, "R6 io above");
    look(32'h5FFF_FFFF, "R6 io below");
    look(32'h6012_3456, "R6 io mid");
    wr(3'd4, 32'h0000_6000);
    look(32'h6012_3456, "R6 io disabled");

    // R7: overlapping apertures
    wr(3'd0, 32'h4000_0091);           // 512 MB at 0x4000_0000
    wr(3'd1, 32'h0000_8006);
    wr(3'd2, 32'h5000_0049);           // 16 MB at 0x5000_0000, prefetch
    wr(3'd3, 32'h0000_C00B);
    wr(3'd4, 32'h0000_5001);           // I/O at 0x50
    wr(3'd5, 32'h0000_3300);
    look(32'h5000_1234, "R7 window 0 wins");
    wr(3'd0, 32'h4000_0090);
    look(32'h5000_1234, "R7 window 1 wins over io");
    wr(3'd2, 32'h5000_0048);
    look(32'h5000_1234, "R7 io last");

    // R8: near-exhaustive sweep of the top byte under a mixed setup
    wr(3'd0, 32'h2000_0061);
    wr(3'd1, 32'h0000_9997);
    wr(3'd2, 32'h8000_00B9);
    wr(3'd3, 32'h0000_0105);
    wr(3'd4, 32'h0000_2101);
    for (int b = 0; b < 256; b++)
      look({8'(b), 24'h5A_5A5B}, "R8 sweep miss/hit");

    // R10: unused select codes change nothing
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'h0000_0000);
    for (int b = 0; b < 256; b += 17)
      look({8'(b), 24'h12_3457}, "R10 unused select");

    // R9: lookup in the write cycle sees old values; new ones next cycle
    wr(3'd0, 32'h3000_0001);
    wr(3'd1, 32'h0000_4446);
    @(negedge clk);
    lk_addr = 32'h3001_0000;
    model(lk_addr);
    wr_en = 1; wr_sel = 3'd0; wr_data = 32'h3000_0000;
    shadow_wr(3'd0, 32'h3000_0000);
    @(negedge clk);
    wr_en = 0;
    check("R9 same-cycle write uses old");
    model(lk_addr);
    @(negedge clk);
    check("R9 write visible next cycle");

    // R1: reset clears programmed state
    @(negedge clk); rst_n = 0;
    for (int i = 0; i < 2; i++) begin sb_base[i] = 0; sb_map[i] = 0; end
    sb_iob = 0; sb_iom = 0;
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    look(32'h2100_0000, "R1 after second reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule